// File: doc/BRIEF.md
# Tagged word stream demultiplexer

This block sits on a 16-bit parallel receive bus that carries sample data and control traffic together. Each accepted word has a two-bit type tag in its top bits. The tag tells the block whether the word is an I sample, a Q sample, a control word, or the end of a command. The block splits these two kinds of traffic apart without any side channel.

Sample words are paired. An I value waits in a holding register until a Q value arrives, and the two then leave together with a one-cycle strobe.

Control words build a command in three steps:
- an opening word carries an 8-bit character code;
- zero or more parameter words follow, each tagged with a six-bit running index;
- a closing word must carry the letter 'E'.

A well-formed command is delivered with a one-cycle strobe, together with its code, its length and its parameter bytes. Any framing mistake throws the pending command away and sets a sticky error flag. Sample traffic interleaved with a command passes straight through and leaves the command state alone.

Top module: `tagdemux`

## Requirements
- R1: A word is consumed only on a clock edge where `wordValid` is high. A word offered with `wordValid` low changes no output and no held state.
- R2: A tag 00 word (bits [15:14]) loads its low 14 bits as a held I value. The next tag 01 word pairs with it. On the edge after that Q word is accepted, `iqValid` is high for exactly one cycle, `iData` shows the held I value and `qData` shows the Q word's low 14 bits.
- R3: A tag 00 word that arrives while an I value is already held replaces the held value and sets `pairErr`. A tag 01 word that arrives with no I held is dropped and also sets `pairErr`. `pairErr` stays set until reset.
- R4: A tag 10 word whose bits [13:8] are 6'b111111 opens a command. It captures bits [7:0] as the command code and sets the parameter count to zero. If a command is already open, the old command is dropped, `cmdErr` is set, and the new one starts.
- R5: Inside an open command, a tag 10 word whose bits [13:8] equal the current parameter count is stored. Its bits [7:0] become the parameter byte at that index, and the count rises by one.
- R6: The pending command is dropped, `cmdErr` is set (sticky until reset) and the block returns to idle when any of these occurs:
  - a parameter word arrives with no command open;
  - a parameter word carries an index other than the current count;
  - a parameter word arrives while `MAX_PARAMS` bytes are already stored.
- R7: A tag 11 word whose bits [7:0] equal 8'h45 closes an open command; bits [13:8] are ignored. On the next edge, `cmdValid` is high for one cycle. At the same time, `cmdCode` holds the code, `cmdLen` holds the parameter count, and `cmdParams[8k+7:8k]` holds parameter byte k for every k below the count.
- R8: A tag 11 word with any other low byte, or any tag 11 word while no command is open, produces no `cmdValid`. It sets `cmdErr` and returns the block to idle.
- R9: Sample words accepted while a command is open are paired exactly as in R2 and R3. They do not change the command code, the count or the stored bytes.
- R10: While the synchronous reset `rst` is high, the block clears all of the following on each edge: both strobes, both error flags, the held I value, the sample outputs, the command code, the count and the parameter buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wordValid | input | 1 | Qualifies `wordIn` on this edge |
| wordIn | input | 16 | Tagged bus word |
| iqValid | output | 1 | One-cycle strobe for a completed I/Q pair |
| iData | output | 14 | I value of the pair |
| qData | output | 14 | Q value of the pair |
| pairErr | output | 1 | Sticky sample pairing error |
| cmdValid | output | 1 | One-cycle strobe for a completed command |
| cmdCode | output | 8 | Command character code |
| cmdLen | output | 6 | Number of parameter bytes |
| cmdParams | output | 8*MAX_PARAMS | Parameter bytes, byte k at bits [8k+7:8k] |
| cmdErr | output | 1 | Sticky command framing error |

## Verification
The bench builds the block with `MAX_PARAMS` set to 4. With that setting, a command that exactly fills the buffer, and one that overruns it by a single byte, both fit in a few words. The same logic then caps the count at 63 with the default setting, where the index value 63 doubles as the opening pattern. The short buffer also lets every stored byte of a full command be compared one by one. Interleaving sample words between parameter words then shows that the two paths do not disturb each other.

// File: rtl/tagdemux_pkg.sv
package tagdemux_pkg;

  typedef enum logic [1:0] {
    TAG_I   = 2'b00,
    TAG_Q   = 2'b01,
    TAG_CTL = 2'b10,
    TAG_END = 2'b11
  } wordTag_e;

  localparam int SEQ_W    = 6;
  localparam int SAMPLE_W = 14;
  localparam logic [SEQ_W-1:0] OPEN_PATTERN = '1;
  localparam logic [7:0]       CLOSE_CHAR   = 8'h45;

  // strobes from the command controller to the datapath
  typedef struct packed {
    logic             store;
    logic [SEQ_W-1:0] slot;
  } ctlStrobe_t;

endpackage

// File: rtl/tagdemux_ctrl.sv
module tagdemux_ctrl
  import tagdemux_pkg::*;
#(
  parameter int MAX_PARAMS = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wordValid,
  input  logic [15:0]      wordIn,
  output ctlStrobe_t       stb,
  output logic             cmdValid,
  output logic [7:0]       cmdCode,
  output logic [SEQ_W-1:0] cmdLen,
  output logic             cmdErr
);

  localparam logic [SEQ_W-1:0] CAP = SEQ_W'(MAX_PARAMS);

  logic             active;
  logic [SEQ_W-1:0] count;
  logic             isCtl, isEnd, isOpen, isParam;
  logic [SEQ_W-1:0] seqField;
  logic [7:0]       lowByte;

  always_comb begin
    isCtl     = wordValid && wordIn[15];
    isEnd     = isCtl && (wordTag_e'(wordIn[15:14]) == TAG_END);
    seqField  = wordIn[13:8];
    lowByte   = wordIn[7:0];
    isOpen    = isCtl && !isEnd && (seqField == OPEN_PATTERN);
    isParam   = isCtl && !isEnd && !isOpen;
    stb.store = isParam && active && (seqField == count) && (count < CAP);
    stb.slot  = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      count    <= '0;
      cmdCode  <= '0;
      cmdValid <= 1'b0;
      cmdErr   <= 1'b0;
    end else begin
      cmdValid <= 1'b0;
      if (isOpen) begin
        if (active) cmdErr <= 1'b1;
        active  <= 1'b1;
        count   <= '0;
        cmdCode <= lowByte;
      end else if (isParam) begin
        if (stb.store) begin
          count <= count + SEQ_W'(1);
        end else begin
          cmdErr <= 1'b1;
          active <= 1'b0;
        end
      end else if (isEnd) begin
        if (active && lowByte == CLOSE_CHAR) cmdValid <= 1'b1;
        else cmdErr <= 1'b1;
        active <= 1'b0;
      end
    end
  end

  assign cmdLen = count;

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmdValid |=> !cmdValid); // R7
  AST_CMD_FROM_CLOSE: assert property (@(posedge clk) disable iff (rst)
    cmdValid |-> $past(wordValid && wordIn[15:14] == 2'b11 && wordIn[7:0] == 8'h45)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cmdErr |=> cmdErr); // R6
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    cmdLen <= CAP); // R5

endmodule

// File: rtl/tagdemux_dp.sv
module tagdemux_dp
  import tagdemux_pkg::*;
#(
  parameter int MAX_PARAMS = 63
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wordValid,
  input  logic [15:0]             wordIn,
  input  ctlStrobe_t              stb,
  output logic                    iqValid,
  output logic [SAMPLE_W-1:0]     iData,
  output logic [SAMPLE_W-1:0]     qData,
  output logic                    pairErr,
  output logic [8*MAX_PARAMS-1:0] cmdParams
);

  logic                isI, isQ;
  logic                haveI;
  logic [SAMPLE_W-1:0] heldI;

  assign isI = wordValid && (wordTag_e'(wordIn[15:14]) == TAG_I);
  assign isQ = wordValid && (wordTag_e'(wordIn[15:14]) == TAG_Q);

  always_ff @(posedge clk) begin
    if (rst) begin
      haveI   <= 1'b0;
      heldI   <= '0;
      iqValid <= 1'b0;
      iData   <= '0;
      qData   <= '0;
      pairErr <= 1'b0;
    end else begin
      iqValid <= 1'b0;
      if (isI) begin
        if (haveI) pairErr <= 1'b1;
        heldI <= wordIn[SAMPLE_W-1:0];
        haveI <= 1'b1;
      end else if (isQ) begin
        if (haveI) begin
          iData   <= heldI;
          qData   <= wordIn[SAMPLE_W-1:0];
          iqValid <= 1'b1;
          haveI   <= 1'b0;
        end else begin
          pairErr <= 1'b1;
        end
      end
    end
  end

  // one byte register per parameter slot
  for (genvar g = 0; g < MAX_PARAMS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (rst) cmdParams[8*g +: 8] <= '0;
      else if (stb.store && stb.slot == SEQ_W'(g)) cmdParams[8*g +: 8] <= wordIn[7:0];
    end
  end

  AST_IQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    iqValid |=> !iqValid); // R2
  AST_PAIR_STICKY: assert property (@(posedge clk) disable iff (rst)
    pairErr |=> pairErr); // R3
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    stb.store |-> (int'(stb.slot) < MAX_PARAMS)); // R6
  AST_STORE_IS_CTL: assert property (@(posedge clk) disable iff (rst)
    stb.store |-> (wordValid && wordIn[15:14] == 2'b10)); // R5

endmodule

// File: rtl/tagdemux.sv
module tagdemux
  import tagdemux_pkg::*;
#(
  parameter int MAX_PARAMS = 63
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wordValid,
  input  logic [15:0]             wordIn,
  output logic                    iqValid,
  output logic [13:0]             iData,
  output logic [13:0]             qData,
  output logic                    pairErr,
  output logic                    cmdValid,
  output logic [7:0]              cmdCode,
  output logic [5:0]              cmdLen,
  output logic [8*MAX_PARAMS-1:0] cmdParams,
  output logic                    cmdErr
);

  ctlStrobe_t stb;

  tagdemux_ctrl #(.MAX_PARAMS(MAX_PARAMS)) u_ctrl (
    .clk(clk), .rst(rst), .wordValid(wordValid), .wordIn(wordIn),
    .stb(stb), .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdLen(cmdLen),
    .cmdErr(cmdErr)
  );

  tagdemux_dp #(.MAX_PARAMS(MAX_PARAMS)) u_dp (
    .clk(clk), .rst(rst), .wordValid(wordValid), .wordIn(wordIn),
    .stb(stb), .iqValid(iqValid), .iData(iData), .qData(qData),
    .pairErr(pairErr), .cmdParams(cmdParams)
  );

endmodule

// File: tb/tagdemux_bench.sv
`timescale 1ns/100ps
module tagdemux_bench;

  localparam int MAXP = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wordValid = 1'b0;
  logic [15:0]     wordIn = '0;
  logic            iqValid, pairErr, cmdValid, cmdErr;
  logic [13:0]     iData, qData;
  logic [7:0]      cmdCode;
  logic [5:0]      cmdLen;
  logic [8*MAXP-1:0] cmdParams;

  tagdemux #(.MAX_PARAMS(MAXP)) u_tagdemux (
    .clk(clk), .rst(rst), .wordValid(wordValid), .wordIn(wordIn),
    .iqValid(iqValid), .iData(iData), .qData(qData), .pairErr(pairErr),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdLen(cmdLen),
    .cmdParams(cmdParams), .cmdErr(cmdErr)
  );

  always #2.5 clk = ~clk;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 1'b0;
  string curReq  = "R10 reset";

  // reference model state
  bit       eActive, eHaveI, eIqV, ePair, eCmdV, eErr;
  int       eCount, eLen;
  int       eCode, eHeldI, eI, eQ;
  int       eBuf[64];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  task automatic modelStep();
    int tag, seq, lo;
    eIqV  = 1'b0;
    eCmdV = 1'b0;
    if (rst) begin
      eActive = 0; eCount = 0; eCode = 0; eHaveI = 0; eHeldI = 0;
      eI = 0; eQ = 0; ePair = 0; eErr = 0; eLen = 0;
      for (int k = 0; k < 64; k++) eBuf[k] = 0;
    end else if (wordValid) begin
      tag = int'(wordIn[15:14]);
      seq = int'(wordIn[13:8]);
      lo  = int'(wordIn[7:0]);
      if (tag == 0) begin
        if (eHaveI) ePair = 1;
        eHeldI = int'(wordIn[13:0]);
        eHaveI = 1;
      end else if (tag == 1) begin
        if (eHaveI) begin
          eI = eHeldI; eQ = int'(wordIn[13:0]); eIqV = 1; eHaveI = 0;
        end else ePair = 1;
      end else if (tag == 2) begin
        if (seq == 63) begin
          if (eActive) eErr = 1;
          eActive = 1; eCount = 0; eCode = lo;
        end else if (eActive && seq == eCount && eCount < MAXP) begin
          eBuf[eCount] = lo; eCount++;
        end else begin
          eErr = 1; eActive = 0;
        end
      end else begin
        if (eActive && lo == 8'h45) begin eCmdV = 1; eLen = eCount; end
        else eErr = 1;
        eActive = 0;
      end
    end
  endtask

  task automatic compareAll();
    chk(iqValid === eIqV, "iqValid", int'(iqValid), int'(eIqV));
    chk(pairErr === ePair, "pairErr", int'(pairErr), int'(ePair));
    chk(cmdValid === eCmdV, "cmdValid", int'(cmdValid), int'(eCmdV));
    chk(cmdErr === eErr, "cmdErr", int'(cmdErr), int'(eErr));
    if (eIqV) begin
      chk(int'(iData) == eI, "iData", int'(iData), eI);
      chk(int'(qData) == eQ, "qData", int'(qData), eQ);
    end
    if (eCmdV) begin
      chk(int'(cmdCode) == eCode, "cmdCode", int'(cmdCode), eCode);
      chk(int'(cmdLen) == eLen, "cmdLen", int'(cmdLen), eLen);
      for (int k = 0; k < eLen; k++)
        chk(int'(cmdParams[k*8 +: 8]) == eBuf[k], "cmdParams byte", int'(cmdParams[k*8 +: 8]), eBuf[k]);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      modelStep();
      #1;
      compareAll();
    end
  end

  function automatic logic [15:0] wI(input int v);  return {2'b00, 14'(v)}; endfunction
  function automatic logic [15:0] wQ(input int v);  return {2'b01, 14'(v)}; endfunction
  function automatic logic [15:0] wOpen(input int c); return {2'b10, 6'h3F, 8'(c)}; endfunction
  function automatic logic [15:0] wPar(input int i, input int b); return {2'b10, 6'(i), 8'(b)}; endfunction
  function automatic logic [15:0] wClose(input int c); return {2'b11, 6'h15, 8'(c)}; endfunction

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    wordValid = 1'b1;
    wordIn    = w;
  endtask

  task automatic sendIdle(input logic [15:0] w);
    @(negedge clk);
    wordValid = 1'b0;
    wordIn    = w;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) sendIdle(16'h0000);
  endtask

  task automatic doReset();
    @(negedge clk);
    wordValid = 1'b0;
    rst = 1'b1;
    gap(2);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    curReq = "R10 reset";
    gap(3);
    @(negedge clk);
    rst = 1'b0;
    chk(cmdLen == 6'd0, "cmdLen after reset", int'(cmdLen), 0);
    chk(cmdCode == 8'd0, "cmdCode after reset", int'(cmdCode), 0);
    chk(cmdParams == '0, "cmdParams after reset", int'(cmdParams), 0);
    chk(iData == 14'd0 && qData == 14'd0, "samples after reset", int'(iData), 0);

    curReq = "R1 unqualified words";
    send(wI(14'h0123));
    sendIdle(wQ(14'h0456));
    sendIdle(wI(14'h3FFF));
    sendIdle(wOpen(8'h41));
    sendIdle(wClose(8'h45));
    send(wQ(14'h0789));
    gap(2);

    curReq = "R2 pairing";
    send(wI(14'h1ABC));
    send(wQ(14'h2DEF));
    send(wI(14'h3FFF));
    gap(1);
    send(wQ(14'h0000));
    gap(2);

    curReq = "R7 command";
    send(wOpen(8'h46));
    send(wPar(0, 8'h11));
    send(wPar(1, 8'h22));
    send(wPar(2, 8'h33));
    send(wClose(8'h45));
    gap(2);
    send(wOpen(8'h5A));
    send(wClose(8'h45));
    gap(2);

    curReq = "R9 samples inside command";
    send(wOpen(8'h53));
    send(wPar(0, 8'hA5));
    send(wI(14'h2AAA));
    send(wQ(14'h1555));
    send(wPar(1, 8'h5A));
    send(wI(14'h0F0F));
    send(wClose(8'h45));
    send(wQ(14'h30F0));
    gap(2);

    curReq = "R5 full buffer boundary";
    send(wOpen(8'h50));
    for (int i = 0; i < MAXP; i++) send(wPar(i, 8'hC0 + i));
    send(wClose(8'h45));
    gap(2);

    curReq = "R3 pairing errors";
    send(wI(14'h0111));
    send(wI(14'h0222));
    send(wQ(14'h0333));
    gap(1);
    doReset();
    send(wQ(14'h0444));
    gap(2);

    curReq = "R4 reopen";
    doReset();
    send(wOpen(8'h41));
    send(wPar(0, 8'h01));
    send(wOpen(8'h42));
    send(wPar(0, 8'h77));
    send(wClose(8'h45));
    gap(2);

    curReq = "R6 wrong index";
    doReset();
    send(wOpen(8'h43));
    send(wPar(1, 8'h99));
    send(wPar(0, 8'h98));
    send(wClose(8'h45));
    gap(2);

    curReq = "R6 overrun";
    doReset();
    send(wOpen(8'h44));
    for (int i = 0; i <= MAXP; i++) send(wPar(i, 8'h10 + i));
    send(wClose(8'h45));
    gap(2);

    curReq = "R6 param while idle";
    doReset();
    send(wPar(0, 8'h12));
    gap(2);

    curReq = "R8 bad close char";
    doReset();
    send(wOpen(8'h47));
    send(wPar(0, 8'h34));
    send(wClose(8'h46));
    gap(2);

    curReq = "R8 close while idle";
    doReset();
    send(wClose(8'h45));
    gap(2);

    curReq = "R10 reset clears flags";
    doReset();
    gap(1);
    chk(!cmdErr && !pairErr, "flags after reset", int'({cmdErr, pairErr}), 0);
    gap(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule